// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block holds the 32-bit fetch address of a simple load/store processor and works out, every cycle, where the next fetch comes from. It looks at the opcode and function fields of the instruction being executed and picks one of five rules: step to the following word, take a PC-relative conditional branch, jump within the current 256 MB region, jump through a register, or jump while saving a return address. The register file supplies the two comparison operands and the jump-register value. The block hands back the return address together with a write strobe, and the register file uses them.

The new address is a combinational function of the current PC, the instruction word and the operand inputs. It is loaded into the PC register on every rising clock edge unless a stall holds the register. A synchronous reset has priority over the stall. A build parameter chooses between two layouts of the target logic. One computes every candidate address in parallel and selects among them. The other shares a single adder between sequential flow, branches and the link value.

Top module: `pc_next_unit`

## Requirements
- R1: When `rst` is high at a rising clock edge, `pc` becomes 0 after that edge, whatever `stall` and the other inputs are.
- R2: When `stall` is high at a rising edge without reset, `pc` keeps its value, and `link_we` is low for as long as `stall` is high.
- R3: When neither `rst` nor `stall` is high at a rising edge, `pc` takes the value that `pc_next` showed before that edge.
- R4: An opcode (bits 31:26) other than 0, 2, 3, 4 and 5 gives `pc_next = pc + 4`. So does opcode 0 with a funct field (bits 5:0) other than 8.
- R5: Opcode 4 gives `pc_next = pc + 4 + (sign-extended bits 15:0) * 4` when `cmp_a == cmp_b`, and `pc + 4` when they differ.
- R6: Opcode 5 gives the same offset target when `cmp_a != cmp_b`, and `pc + 4` when they are equal.
- R7: Opcode 2 gives `pc_next = {pc[31:28], instr[25:0], 2'b00}`.
- R8: Opcode 3 gives the same target as R7. While `stall` is low it also raises `link_we`, with `link_val = pc + 4`; that is the value to be written to register 31.
- R9: Opcode 0 with funct 8 gives `pc_next = jr_val`, passed through unchanged.
- R10: `link_we` is low for every opcode other than 3.
- R11: All address sums wrap modulo 2^32. For example, `pc + 4` from 0xFFFFFFFC is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Holds the PC and blocks the link write |
| instr | input | 32 | Instruction word being executed |
| cmp_a | input | 32 | Value of the rs register, for the branch comparison |
| cmp_b | input | 32 | Value of the rt register, for the branch comparison |
| jr_val | input | 32 | Value of the rs register, used as the jump-register target |
| pc | output | 32 | Current fetch address |
| pc_next | output | 32 | Address the PC loads at the next unstalled edge |
| link_val | output | 32 | Return address (PC + 4) |
| link_we | output | 1 | Strobe that writes the return address to register 31 |

## Verification
Random instruction words are weighted toward the five control opcodes. Random comparison operands are forced equal about half the time, so each branch opcode is seen both taken and not taken, and a reversed equality sense shows up at once. Opcode 0 is tried with funct 8 and with other funct values, which separates jump-register from ordinary register-format words. Directed cases place the PC at region edges and at the top of the address space, and use the most negative and most positive branch offsets. These cases separate correct modulo-2^32 wrap, sign extension and upper-bit retention from truncation mistakes. Stalls and resets are mixed in, including a reset during a stall, which checks the hold rule, the reset priority and the gating of the link strobe.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

   typedef enum logic [1:0] {
      NXT_SEQ    = 2'd0,
      NXT_BRANCH = 2'd1,
      NXT_JUMP   = 2'd2,
      NXT_JREG   = 2'd3
   } nxt_kind_e;

   typedef struct packed {
      nxt_kind_e kind;
      logic      link;
   } nxt_sel_t;

   localparam int unsigned OPC_W = 6;
   localparam int unsigned FN_W  = 6;

   localparam logic [OPC_W-1:0] OPC_REG  = 6'd0;
   localparam logic [OPC_W-1:0] OPC_JMP  = 6'd2;
   localparam logic [OPC_W-1:0] OPC_JAL  = 6'd3;
   localparam logic [OPC_W-1:0] OPC_BEQ  = 6'd4;
   localparam logic [OPC_W-1:0] OPC_BNE  = 6'd5;
   localparam logic [FN_W-1:0]  FN_JREG  = 6'd8;

   localparam int unsigned INSTR_W   = 32;
   localparam int unsigned IDX_W     = 26;
   localparam int unsigned IMM_W     = 16;
   localparam int unsigned REGION_LO = IDX_W + 2;

endpackage

// File: rtl/pcu_decode.sv
module pcu_decode
   import pcu_pkg::*;
#(
   parameter int unsigned REG_W = 32
) (
   input  logic [OPC_W-1:0] opcode,
   input  logic [FN_W-1:0]  funct,
   input  logic [REG_W-1:0] cmp_a,
   input  logic [REG_W-1:0] cmp_b,
   output nxt_sel_t         sel
);

   logic same;

   assign same = (cmp_a == cmp_b);

   always_comb begin
      sel.kind = NXT_SEQ;
      sel.link = 1'b0;
      unique case (opcode)
         OPC_BEQ: if (same)  sel.kind = NXT_BRANCH;
         OPC_BNE: if (!same) sel.kind = NXT_BRANCH;
         OPC_JMP: sel.kind = NXT_JUMP;
         OPC_JAL: begin
            sel.kind = NXT_JUMP;
            sel.link = 1'b1;
         end
         OPC_REG: if (funct == FN_JREG) sel.kind = NXT_JREG;
         default: sel.kind = NXT_SEQ;
      endcase
   end

endmodule

// File: rtl/pcu_target.sv
module pcu_target
   import pcu_pkg::*;
#(
   parameter int unsigned ADDR_W           = 32,
   parameter bit          PARALLEL_TARGETS = 1'b1
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [IDX_W-1:0]  ins_low,
   input  logic [ADDR_W-1:0] jr_val,
   input  nxt_kind_e         kind,
   output logic [ADDR_W-1:0] pc_next,
   output logic [ADDR_W-1:0] link_val
);

   localparam int unsigned EXT_W = ADDR_W - IMM_W - 2;

   logic [IMM_W-1:0]  imm;
   logic [ADDR_W-1:0] br_off;
   logic [ADDR_W-1:0] jmp_tgt;

   assign imm     = ins_low[IMM_W-1:0];
   assign br_off  = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
   assign jmp_tgt = {pc[ADDR_W-1:REGION_LO], ins_low, 2'b00};

   generate
      if (PARALLEL_TARGETS) begin : g_parallel
         logic [ADDR_W-1:0] seq_tgt;
         logic [ADDR_W-1:0] br_tgt;

         assign seq_tgt  = pc + ADDR_W'(4);
         assign br_tgt   = seq_tgt + br_off;
         assign link_val = seq_tgt;

         always_comb begin
            unique case (kind)
               NXT_BRANCH: pc_next = br_tgt;
               NXT_JUMP:   pc_next = jmp_tgt;
               NXT_JREG:   pc_next = jr_val;
               default:    pc_next = seq_tgt;
            endcase
         end
      end else begin : g_shared
         logic [ADDR_W-1:0] addend;
         logic [ADDR_W-1:0] sum;

         assign addend   = (kind == NXT_BRANCH) ? (br_off + ADDR_W'(4)) : ADDR_W'(4);
         assign sum      = pc + addend;
         assign link_val = sum;

         always_comb begin
            unique case (kind)
               NXT_JUMP: pc_next = jmp_tgt;
               NXT_JREG: pc_next = jr_val;
               default:  pc_next = sum;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/pcu_pc_reg.sv
module pcu_pc_reg #(
   parameter int unsigned        ADDR_W     = 32,
   parameter logic [ADDR_W-1:0]  RESET_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              hold,
   input  logic [ADDR_W-1:0] d,
   output logic [ADDR_W-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst)
         q <= RESET_ADDR;
      else if (!hold)
         q <= d;
   end

endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
   import pcu_pkg::*;
#(
   parameter int unsigned       ADDR_W           = 32,
   parameter int unsigned       REG_W            = 32,
   parameter logic [ADDR_W-1:0] RESET_ADDR       = '0,
   parameter bit                PARALLEL_TARGETS = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                stall,
   input  logic [INSTR_W-1:0]  instr,
   input  logic [REG_W-1:0]    cmp_a,
   input  logic [REG_W-1:0]    cmp_b,
   input  logic [ADDR_W-1:0]   jr_val,
   output logic [ADDR_W-1:0]   pc,
   output logic [ADDR_W-1:0]   pc_next,
   output logic [ADDR_W-1:0]   link_val,
   output logic                link_we
);

   generate
      if (ADDR_W <= REGION_LO) begin : g_bad_addr_w
         $error("pc_next_unit: ADDR_W must exceed the pseudo-direct index span");
      end
      if (RESET_ADDR[1:0] != 2'b00) begin : g_bad_reset
         $error("pc_next_unit: RESET_ADDR must be word aligned");
      end
      if (REG_W == 0) begin : g_bad_reg_w
         $error("pc_next_unit: REG_W must be non-zero");
      end
   endgenerate

   nxt_sel_t          sel;
   logic [ADDR_W-1:0] pc_q;
   logic [ADDR_W-1:0] nxt;
   logic [ADDR_W-1:0] ret_addr;

   pcu_decode #(
      .REG_W (REG_W)
   ) u_decode (
      .opcode (instr[INSTR_W-1 -: OPC_W]),
      .funct  (instr[FN_W-1:0]),
      .cmp_a  (cmp_a),
      .cmp_b  (cmp_b),
      .sel    (sel)
   );

   pcu_target #(
      .ADDR_W           (ADDR_W),
      .PARALLEL_TARGETS (PARALLEL_TARGETS)
   ) u_target (
      .pc       (pc_q),
      .ins_low  (instr[IDX_W-1:0]),
      .jr_val   (jr_val),
      .kind     (sel.kind),
      .pc_next  (nxt),
      .link_val (ret_addr)
   );

   pcu_pc_reg #(
      .ADDR_W     (ADDR_W),
      .RESET_ADDR (RESET_ADDR)
   ) u_pc_reg (
      .clk  (clk),
      .rst  (rst),
      .hold (stall),
      .d    (nxt),
      .q    (pc_q)
   );

   assign pc       = pc_q;
   assign pc_next  = nxt;
   assign link_val = ret_addr;
   assign link_we  = sel.link & ~stall;

endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned REG_W  = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              stall,
   input logic [31:0]       instr,
   input logic [REG_W-1:0]  cmp_a,
   input logic [REG_W-1:0]  cmp_b,
   input logic [ADDR_W-1:0] jr_val,
   input logic [ADDR_W-1:0] pc,
   input logic [ADDR_W-1:0] pc_next,
   input logic [ADDR_W-1:0] link_val,
   input logic              link_we
);

   logic [5:0]        op;
   logic              is_jr;
   logic              is_other;
   logic [ADDR_W-1:0] step4;
   logic [ADDR_W-1:0] rel_tgt;

   assign op       = instr[31:26];
   assign is_jr    = (op == 6'd0) && (instr[5:0] == 6'd8);
   assign is_other = !is_jr && (op != 6'd2) && (op != 6'd3) && (op != 6'd4) && (op != 6'd5);
   assign step4    = pc + ADDR_W'(4);
   assign rel_tgt  = step4 + {{(ADDR_W-18){instr[15]}}, instr[15:0], 2'b00};

   p_reset_zero_r1: assert property (@(posedge clk) rst |=> (pc == '0));

   p_stall_hold_r2: assert property (@(posedge clk) disable iff (rst)
      stall |=> $stable(pc));

   p_stall_nolink_r2: assert property (@(posedge clk) disable iff (rst)
      stall |-> !link_we);

   p_advance_r3: assert property (@(posedge clk) disable iff (rst)
      !stall |=> (pc == $past(pc_next)));

   p_seq_r4: assert property (@(posedge clk) disable iff (rst)
      is_other |-> (pc_next == step4));

   p_beq_r5: assert property (@(posedge clk) disable iff (rst)
      (op == 6'd4) |-> (pc_next == ((cmp_a == cmp_b) ? rel_tgt : step4)));

   p_bne_r6: assert property (@(posedge clk) disable iff (rst)
      (op == 6'd5) |-> (pc_next == ((cmp_a != cmp_b) ? rel_tgt : step4)));

   p_region_r7: assert property (@(posedge clk) disable iff (rst)
      ((op == 6'd2) || (op == 6'd3)) |->
         (pc_next[ADDR_W-1:28] == pc[ADDR_W-1:28]) && (pc_next[27:0] == {instr[25:0], 2'b00}));

   p_link_r8: assert property (@(posedge clk) disable iff (rst)
      ((op == 6'd3) && !stall) |-> (link_we && (link_val == step4)));

   p_jreg_r9: assert property (@(posedge clk) disable iff (rst)
      is_jr |-> (pc_next == jr_val));

   p_nolink_r10: assert property (@(posedge clk) disable iff (rst)
      (op != 6'd3) |-> !link_we);

endmodule

bind pc_next_unit pcu_checker #(
   .ADDR_W (ADDR_W),
   .REG_W  (REG_W)
) i_pcu_checker (
   .clk      (clk),
   .rst      (rst),
   .stall    (stall),
   .instr    (instr),
   .cmp_a    (cmp_a),
   .cmp_b    (cmp_b),
   .jr_val   (jr_val),
   .pc       (pc),
   .pc_next  (pc_next),
   .link_val (link_val),
   .link_we  (link_we)
);

// File: tb/test_pc_next_unit.sv
module test_pc_next_unit;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        stall = 1'b0;
   logic [31:0] instr = '0;
   logic [31:0] cmp_a = '0;
   logic [31:0] cmp_b = '0;
   logic [31:0] jr_val = '0;
   logic [31:0] pc;
   logic [31:0] pc_next;
   logic [31:0] link_val;
   logic        link_we;

   int unsigned checks = 0;
   int unsigned failures = 0;
   bit          finished = 1'b0;
   logic [31:0] exp_pc = '0;
   string       pc_tag = "R1";

   always #4 clk = ~clk;

   pc_next_unit i_pc_next_unit (
      .clk      (clk),
      .rst      (rst),
      .stall    (stall),
      .instr    (instr),
      .cmp_a    (cmp_a),
      .cmp_b    (cmp_b),
      .jr_val   (jr_val),
      .pc       (pc),
      .pc_next  (pc_next),
      .link_val (link_val),
      .link_we  (link_we)
   );

   function automatic logic [31:0] f_next(logic [31:0] p, logic [31:0] w,
                                          logic [31:0] a, logic [31:0] b, logic [31:0] j);
      logic [31:0] s4  = p + 32'd4;
      logic [31:0] off = {{14{w[15]}}, w[15:0], 2'b00};
      case (w[31:26])
         6'd4:       return (a == b) ? s4 + off : s4;
         6'd5:       return (a != b) ? s4 + off : s4;
         6'd2, 6'd3: return {p[31:28], w[25:0], 2'b00};
         6'd0:       return (w[5:0] == 6'd8) ? j : s4;
         default:    return s4;
      endcase
   endfunction

   function automatic string f_tag(logic [31:0] w);
      case (w[31:26])
         6'd4:    return "R5";
         6'd5:    return "R6";
         6'd2:    return "R7";
         6'd3:    return "R8";
         6'd0:    return (w[5:0] == 6'd8) ? "R9" : "R4";
         default: return "R4";
      endcase
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
      end
   endtask

   task automatic step(logic [31:0] w, logic [31:0] a, logic [31:0] b,
                       logic [31:0] j, logic st, logic r);
      logic        exp_we;
      logic [31:0] exp_nx;
      @(negedge clk);
      instr = w; cmp_a = a; cmp_b = b; jr_val = j; stall = st; rst = r;
      #1;
      chk(pc_tag, pc, exp_pc, "pc");
      exp_nx = f_next(exp_pc, w, a, b, j);
      chk(f_tag(w), pc_next, exp_nx, "pc_next");
      exp_we = (w[31:26] == 6'd3) && !st;
      chk(st ? "R2" : (w[31:26] == 6'd3 ? "R8" : "R10"), {31'd0, link_we}, {31'd0, exp_we}, "link_we");
      if (exp_we) chk("R8", link_val, exp_pc + 32'd4, "link_val");
      @(posedge clk);
      if (r) begin
         exp_pc = '0;     pc_tag = "R1";
      end else if (st) begin
         pc_tag = "R2";
      end else begin
         exp_pc = exp_nx; pc_tag = "R3";
      end
   endtask

   function automatic logic [31:0] jr_w();
      return {6'd0, 5'd17, 15'd0, 6'd8};
   endfunction

   initial begin
      #(8 * 150000);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      step(32'h0800_0040, 0, 0, 0, 1'b0, 1'b1);
      step(32'hFC00_0000, 0, 0, 0, 1'b0, 1'b1);
      // R1 reset state, then R4 sequential from zero
      step(32'hFC00_0000, 0, 0, 0, 1'b0, 1'b0);
      step(32'h0000_0020, 0, 0, 0, 1'b0, 1'b0);
      // R11 wrap: jr to top of space, then sequential step to 0
      step(jr_w(), 0, 0, 32'hFFFF_FFFC, 1'b0, 1'b0);
      step(32'h2000_0001, 0, 0, 0, 1'b0, 1'b0);
      // R5 most negative offset from 0 wraps (R11)
      step({6'd4, 10'd0, 16'h8000}, 5, 5, 0, 1'b0, 1'b0);
      // R6 not taken when equal, then taken with max positive offset
      step({6'd5, 10'd0, 16'h7FFF}, 9, 9, 0, 1'b0, 1'b0);
      step({6'd5, 10'd0, 16'h7FFF}, 9, 8, 0, 1'b0, 1'b0);
      // R7 jump keeps upper region bits
      step(jr_w(), 0, 0, 32'hF123_4560, 1'b0, 1'b0);
      step({6'd2, 26'h3FF_FFFF}, 0, 0, 0, 1'b0, 1'b0);
      // R8 jal, stalled first (R2: no link, pc held), then released
      step({6'd3, 26'h000_0001}, 0, 0, 0, 1'b1, 1'b0);
      step({6'd3, 26'h000_0001}, 0, 0, 0, 1'b0, 1'b0);
      // R9 unaligned jr value passes through
      step(jr_w(), 0, 0, 32'h1234_5677, 1'b0, 1'b0);
      // R1 reset wins over stall
      step(32'h0000_0000, 0, 0, 0, 1'b1, 1'b1);
      step(32'h0000_0000, 0, 0, 0, 1'b0, 1'b0);

      for (int i = 0; i < 3000; i++) begin
         logic [31:0] w = $urandom;
         logic [31:0] a = $urandom;
         logic [31:0] b = ($urandom % 2 == 0) ? a : $urandom;
         logic [31:0] j = {$urandom} & 32'hFFFF_FFFC;
         case ($urandom % 8)
            0: w = {6'd0, w[25:6], 6'd8};
            1: w = {6'd0, w[25:0]};
            2: w = {6'd2, w[25:0]};
            3: w = {6'd3, w[25:0]};
            4: w = {6'd4, w[25:0]};
            5: w = {6'd5, w[25:0]};
            default: ;
         endcase
         step(w, a, b, j, ($urandom % 8) == 0, ($urandom % 97) == 0);
      end

      @(negedge clk);
      #1;
      chk(pc_tag, pc, exp_pc, "pc final");
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule